// File: doc/BRIEF.md
# USART Control Write Sequencer

This block is the processor-facing control section of a programmable serial transceiver. It watches an active-low chip select, read strobe and write strobe, together with a control/data select line. Control writes are not addressed. A small state machine decides what each control write means from the order in which the writes arrive. The first control write after any reset is the mode word. If that mode word picks synchronous operation, one or two sync-character writes follow. Every later control write is a command word.

The decoded mode fields, the sync characters and the command bits drive the serial engines, which sit outside this block. The command bits are transmit enable, receive enable, break, and the two modem outputs. The block also keeps sticky error flags from the receiver's error events. It answers reads with either the received character or an assembled status word. The bus is split into an input byte, an output byte and an output enable, and a pad at chip level joins them into one bidirectional bus.

States and transitions of the sequencer:
- `ST_MODE`: waits for the mode word.
  - Goes to `ST_SYNC1` when the mode word has baud field 00.
  - Goes to `ST_CMD` for any other baud field.
- `ST_SYNC1`: stores the first sync character.
  - Goes to `ST_CMD` when the single-sync bit was set in the mode word.
  - Goes to `ST_SYNC2` otherwise.
- `ST_SYNC2`: stores the second sync character, then goes to `ST_CMD`.
- `ST_CMD`: loads command words.
  - Goes back to `ST_MODE` on a command with the internal-reset bit set.
  - Goes back to `ST_MODE` on the external reset, which acts from any state.

Top module: `usart_ctl_seq`

## Requirements
- R1: While `rst` is high and after it falls, the sequencer waits for a mode word and all command outputs are inactive: `tx_en`=0, `rx_en`=0, `rts_n`=1, `dtr_n`=1, no break. The error flags are clear.
- R2: The first control write (`cd`=1) after reset loads the mode fields: `baud_sel`=[1:0], `len_sel`=[3:2], `par_en`=[4], `par_even`=[5], `frame_ctl`=[7:6]. If [1:0] is not 00, the next control write is a command word.
- R3: A mode word with [1:0]=00 is synchronous. Bit [7] set means one sync character follows, and bit [7] clear means two follow. These writes load `sync_a` and then `sync_b`. None of them acts as a command. The next control write after them is a command.
- R4: Each command word replaces all command outputs. Bit 0 sets `tx_en`, bit 2 sets `rx_en`, bit 1 drives `dtr_n` low, and bit 5 drives `rts_n` low.
- R5: Command bit 3 (break) forces `txd` low whatever `txd_raw` is. Without break, `txd` follows `txd_raw`.
- R6: Command bit 6 (internal reset) sends the sequencer back to waiting for a mode word. It clears every command output, and the other bits of that write are ignored. The mode fields keep their values until the next mode word.
- R7: A data write (`cd`=0) loads `tx_data` and raises `tx_load` for the single cycle in which the strobe is first seen. It does not move the sequencer.
- R8: A data read (`cd`=0) puts `rx_data` on `bus_out` and raises `rx_take` for one cycle. A control read puts the status word on `bus_out`. The status word is: [0] `tx_buf_rdy` AND `tx_en`, [1] `rx_full`, [2] `tx_idle`, [3] parity flag, [4] overrun flag, [5] framing flag, [6] `syn_det`, [7] NOT `dsr_n`.
- R9: The error flags are sticky and are set by one-cycle event inputs. A command with bit 4 clears them, and so does an internal reset. An event that arrives in the same cycle as a clear wins over the clear.
- R10: `bus_oe` is high exactly while `cs_n` and `rd_n` are both low. Strobes with `cs_n` high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 = control/status, 0 = data |
| bus_in | input | 8 | Write data from the processor |
| bus_out | output | 8 | Read data to the processor |
| bus_oe | output | 1 | Output enable for the bus pad |
| rx_data | input | 8 | Character from the receiver |
| rx_full | input | 1 | Receiver holds a character |
| tx_buf_rdy | input | 1 | Transmitter can take a character |
| tx_idle | input | 1 | Transmitter has nothing left to send |
| syn_det | input | 1 | Sync or break detect from the receiver |
| dsr_n | input | 1 | Modem data-set-ready, active low |
| ev_parity | input | 1 | Parity error event pulse |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_framing | input | 1 | Framing error event pulse |
| txd_raw | input | 1 | Serial output from the transmit shifter |
| txd | output | 1 | Serial output after break forcing |
| tx_data | output | 8 | Character written for transmission |
| tx_load | output | 1 | One-cycle pulse on a data write |
| rx_take | output | 1 | One-cycle pulse on a data read |
| baud_sel | output | 2 | Baud factor, 00 = synchronous |
| len_sel | output | 2 | Character length code, 5 to 8 bits |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| frame_ctl | output | 2 | Stop bits (async) or {single sync, external sync} (sync) |
| sync_a | output | 8 | First sync character |
| sync_b | output | 8 | Second sync character |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |

## Verification
The properties assume that every strobe is a clean level held for at least one clock edge. They assume that `cd` and `bus_in` are steady while a strobe is low. They also assume the error event inputs are single-cycle pulses, so one rising strobe edge means exactly one write or read. The bench changes every input only on the falling clock edge. It holds each strobe low across exactly one rising edge, and it releases the strobe before starting the next access. Each access therefore gives a single decoded event at a known cycle.

// File: rtl/usart_ctl_pkg.sv
package usart_ctl_pkg;

    localparam int BUS_W   = 8;
    localparam int NUM_ERR = 3;

    // Command word bit positions
    localparam int CB_TXEN  = 0;
    localparam int CB_DTR   = 1;
    localparam int CB_RXEN  = 2;
    localparam int CB_BRK   = 3;
    localparam int CB_ECLR  = 4;
    localparam int CB_RTS   = 5;
    localparam int CB_IRST  = 6;

    // Mode word bit positions
    localparam int MB_SINGLE = 7;

    typedef enum logic [1:0] {
        ST_MODE  = 2'd0,
        ST_SYNC1 = 2'd1,
        ST_SYNC2 = 2'd2,
        ST_CMD   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic txen;
        logic dtr;
        logic rxen;
        logic brk;
        logic rts;
    } cmd_t;

endpackage

// File: rtl/usart_bus_if.sv
module usart_bus_if (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic cd,
    output logic wr_ctl,
    output logic wr_dat,
    output logic rd_dat,
    output logic rd_act
);

    logic wr_act;
    logic wr_q;
    logic rd_q;
    logic wr_evt;
    logic rd_evt;

    assign wr_act = ~cs_n & ~wr_n;
    assign rd_act = ~cs_n & ~rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    assign wr_evt = wr_act & ~wr_q;
    assign rd_evt = rd_act & ~rd_q;

    assign wr_ctl = wr_evt & cd;
    assign wr_dat = wr_evt & ~cd;
    assign rd_dat = rd_evt & ~cd;

endmodule

// File: rtl/usart_seq_fsm.sv
module usart_seq_fsm
    import usart_ctl_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_ctl,
    input  logic         wr_dat,
    input  logic [W-1:0] din,
    output seq_state_e   state,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] sync_a_q,
    output logic [W-1:0] sync_b_q,
    output cmd_t         cmd_q,
    output logic         err_clr,
    output logic [W-1:0] tx_data_q
);

    seq_state_e state_nx;
    logic       is_sync;
    logic       single_sync;

    assign is_sync     = (din[1:0] == 2'b00);
    assign single_sync = mode_q[MB_SINGLE];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_MODE;
        else     state <= state_nx;
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_MODE:  if (wr_ctl) state_nx = is_sync ? ST_SYNC1 : ST_CMD;
            ST_SYNC1: if (wr_ctl) state_nx = single_sync ? ST_CMD : ST_SYNC2;
            ST_SYNC2: if (wr_ctl) state_nx = ST_CMD;
            ST_CMD:   if (wr_ctl && din[CB_IRST]) state_nx = ST_MODE;
            default:  state_nx = ST_MODE;
        endcase
    end

    assign err_clr = wr_ctl && (state == ST_CMD) && (din[CB_ECLR] || din[CB_IRST]);

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            sync_a_q  <= '0;
            sync_b_q  <= '0;
            cmd_q     <= '0;
            tx_data_q <= '0;
        end else begin
            if (wr_dat) tx_data_q <= din;
            if (wr_ctl) begin
                unique case (state)
                    ST_MODE:  mode_q   <= din;
                    ST_SYNC1: sync_a_q <= din;
                    ST_SYNC2: sync_b_q <= din;
                    ST_CMD: begin
                        if (din[CB_IRST]) begin
                            cmd_q <= '0;
                        end else begin
                            cmd_q.txen <= din[CB_TXEN];
                            cmd_q.dtr  <= din[CB_DTR];
                            cmd_q.rxen <= din[CB_RXEN];
                            cmd_q.brk  <= din[CB_BRK];
                            cmd_q.rts  <= din[CB_RTS];
                        end
                    end
                    default: cmd_q <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/usart_status.sv
module usart_status
    import usart_ctl_pkg::*;
#(
    parameter int NE = NUM_ERR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NE-1:0] err_evt,
    input  logic          err_clr,
    output logic [NE-1:0] err_flag
);

    for (genvar g = 0; g < NE; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             err_flag[g] <= 1'b0;
            else if (err_evt[g]) err_flag[g] <= 1'b1;
            else if (err_clr)    err_flag[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/usart_ctl_seq.sv
module usart_ctl_seq
    import usart_ctl_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic         cd,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    input  logic [W-1:0] rx_data,
    input  logic         rx_full,
    input  logic         tx_buf_rdy,
    input  logic         tx_idle,
    input  logic         syn_det,
    input  logic         dsr_n,
    input  logic         ev_parity,
    input  logic         ev_overrun,
    input  logic         ev_framing,
    input  logic         txd_raw,
    output logic         txd,
    output logic [W-1:0] tx_data,
    output logic         tx_load,
    output logic         rx_take,
    output logic [1:0]   baud_sel,
    output logic [1:0]   len_sel,
    output logic         par_en,
    output logic         par_even,
    output logic [1:0]   frame_ctl,
    output logic [W-1:0] sync_a,
    output logic [W-1:0] sync_b,
    output logic         tx_en,
    output logic         rx_en,
    output logic         rts_n,
    output logic         dtr_n
);

    logic                wr_ctl;
    logic                wr_dat;
    logic                rd_dat;
    logic                rd_act;
    logic                err_clr;
    seq_state_e          seq_state;
    cmd_t                cmd;
    logic [W-1:0]        mode_w;
    logic [NUM_ERR-1:0]  err_flags;
    logic [W-1:0]        status_w;

    usart_bus_if u_bus (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .cd     (cd),
        .wr_ctl (wr_ctl),
        .wr_dat (wr_dat),
        .rd_dat (rd_dat),
        .rd_act (rd_act)
    );

    usart_seq_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_ctl    (wr_ctl),
        .wr_dat    (wr_dat),
        .din       (bus_in),
        .state     (seq_state),
        .mode_q    (mode_w),
        .sync_a_q  (sync_a),
        .sync_b_q  (sync_b),
        .cmd_q     (cmd),
        .err_clr   (err_clr),
        .tx_data_q (tx_data)
    );

    usart_status #(.NE(NUM_ERR)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .err_evt  ({ev_framing, ev_overrun, ev_parity}),
        .err_clr  (err_clr),
        .err_flag (err_flags)
    );

    assign baud_sel  = mode_w[1:0];
    assign len_sel   = mode_w[3:2];
    assign par_en    = mode_w[4];
    assign par_even  = mode_w[5];
    assign frame_ctl = mode_w[7:6];

    assign tx_en = cmd.txen;
    assign rx_en = cmd.rxen;
    assign rts_n = ~cmd.rts;
    assign dtr_n = ~cmd.dtr;
    assign txd   = txd_raw & ~cmd.brk;

    assign tx_load = wr_dat;
    assign rx_take = rd_dat;

    assign status_w = {~dsr_n, syn_det, err_flags, tx_idle, rx_full, tx_buf_rdy & cmd.txen};
    assign bus_oe   = rd_act;
    assign bus_out  = cd ? status_w : rx_data;

endmodule

// File: rtl/usart_ctl_chk.sv
module usart_ctl_chk
    import usart_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input seq_state_e         state,
    input logic               wr_ctl,
    input logic               wr_dat,
    input logic [7:0]         din,
    input logic               txd,
    input logic               tx_en,
    input logic               rts_n,
    input logic               dtr_n,
    input logic [NUM_ERR-1:0] err_flags,
    input logic [NUM_ERR-1:0] err_evt
);

    AST_RESET_MODE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state == ST_MODE && !tx_en && rts_n && dtr_n)); // R1

    AST_ASYNC_TO_CMD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MODE && wr_ctl && din[1:0] != 2'b00) |=> (state == ST_CMD)); // R2

    AST_SYNC_TO_SYNC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MODE && wr_ctl && din[1:0] == 2'b00) |=> (state == ST_SYNC1)); // R3

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD && wr_ctl && din[CB_BRK] && !din[CB_IRST]) |=> !txd); // R5

    AST_IRST_MODE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD && wr_ctl && din[CB_IRST]) |=> (state == ST_MODE && !tx_en && rts_n && dtr_n)); // R6

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_dat |=> $stable(state)); // R7

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD && wr_ctl && din[CB_ECLR] && err_evt == '0) |=> (err_flags == '0)); // R9

endmodule

bind usart_ctl_seq usart_ctl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (seq_state),
    .wr_ctl    (wr_ctl),
    .wr_dat    (wr_dat),
    .din       (bus_in),
    .txd       (txd),
    .tx_en     (tx_en),
    .rts_n     (rts_n),
    .dtr_n     (dtr_n),
    .err_flags (err_flags),
    .err_evt   ({ev_framing, ev_overrun, ev_parity})
);

// File: tb/test_usart_ctl_seq.sv
module test_usart_ctl_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] rx_data = 8'h3C;
    logic       rx_full = 1'b0, tx_buf_rdy = 1'b1, tx_idle = 1'b1;
    logic       syn_det = 1'b0, dsr_n = 1'b1;
    logic       ev_parity = 1'b0, ev_overrun = 1'b0, ev_framing = 1'b0;
    logic       txd_raw = 1'b1;
    logic       txd;
    logic [7:0] tx_data;
    logic       tx_load, rx_take;
    logic [1:0] baud_sel, len_sel, frame_ctl;
    logic       par_en, par_even;
    logic [7:0] sync_a, sync_b;
    logic       tx_en, rx_en, rts_n, dtr_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    usart_ctl_seq i_usart_ctl_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .rx_data(rx_data), .rx_full(rx_full), .tx_buf_rdy(tx_buf_rdy),
        .tx_idle(tx_idle), .syn_det(syn_det), .dsr_n(dsr_n),
        .ev_parity(ev_parity), .ev_overrun(ev_overrun), .ev_framing(ev_framing),
        .txd_raw(txd_raw), .txd(txd), .tx_data(tx_data), .tx_load(tx_load),
        .rx_take(rx_take), .baud_sel(baud_sel), .len_sel(len_sel),
        .par_en(par_en), .par_even(par_even), .frame_ctl(frame_ctl),
        .sync_a(sync_a), .sync_b(sync_b), .tx_en(tx_en), .rx_en(rx_en),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Strobe held across exactly one rising edge; sampled on the following falling edge.
    task automatic bus_write(input logic is_ctl, input logic [7:0] val);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; cd = is_ctl; bus_in = val;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cmd_bits(input string req, input logic [3:0] exp);
        check(req, {4'd0, tx_en, rx_en, rts_n, dtr_n}, {4'd0, exp});
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        cmd_bits("R1", 4'b0011);
        rst = 1'b0;
        @(negedge clk);
        cmd_bits("R1", 4'b0011);
        check("R1 txd", {7'd0, txd}, 8'h01);
        // first control write after reset must be a mode word
        bus_write(1'b1, 8'h27);
        check("R1 mode", {6'd0, baud_sel}, 8'h03);
        cmd_bits("R1", 4'b0011);
    endtask

    task automatic t_async_mode;
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        bus_write(1'b1, 8'hDE);
        check("R2 baud",  {6'd0, baud_sel},  8'h02);
        check("R2 len",   {6'd0, len_sel},   8'h03);
        check("R2 par",   {6'd0, par_even, par_en}, 8'h01);
        check("R2 frame", {6'd0, frame_ctl}, 8'h03);
        cmd_bits("R2", 4'b0011);
        bus_write(1'b1, 8'h27);
        cmd_bits("R4", 4'b1100);
        bus_write(1'b1, 8'h04);
        cmd_bits("R4 replace", 4'b0111);
    endtask

    task automatic t_break;
        txd_raw = 1'b1;
        bus_write(1'b1, 8'h09);
        check("R5 low", {7'd0, txd}, 8'h00);
        txd_raw = 1'b0; #1;
        check("R5 low2", {7'd0, txd}, 8'h00);
        bus_write(1'b1, 8'h01);
        txd_raw = 1'b1; #1;
        check("R5 follow", {7'd0, txd}, 8'h01);
        txd_raw = 1'b0; #1;
        check("R5 follow0", {7'd0, txd}, 8'h00);
        txd_raw = 1'b1;
    endtask

    task automatic t_internal_reset;
        bus_write(1'b1, 8'h27);
        bus_write(1'b1, 8'h7F);
        cmd_bits("R6 cleared", 4'b0011);
        check("R6 txd", {7'd0, txd}, 8'h01);
        check("R6 mode kept", {6'd0, baud_sel}, 8'h02);
        // the next control write is a mode word again
        bus_write(1'b1, 8'h1C);
        check("R6 new mode", {4'd0, len_sel, baud_sel}, 8'h0C);
        cmd_bits("R6", 4'b0011);
    endtask

    task automatic t_two_sync;
        bus_write(1'b1, 8'h16);
        cmd_bits("R3 sync1 not cmd", 4'b0011);
        bus_write(1'b1, 8'h2D);
        cmd_bits("R3 sync2 not cmd", 4'b0011);
        check("R3 sync_a", sync_a, 8'h16);
        check("R3 sync_b", sync_b, 8'h2D);
        bus_write(1'b1, 8'h01);
        cmd_bits("R3 then cmd", 4'b1011);
    endtask

    task automatic t_one_sync;
        bus_write(1'b1, 8'h40);
        bus_write(1'b1, 8'h80);
        check("R3 single", {6'd0, frame_ctl}, 8'h02);
        bus_write(1'b1, 8'h27);
        check("R3 one sync_a", sync_a, 8'h27);
        cmd_bits("R3 one not cmd", 4'b0011);
        bus_write(1'b1, 8'h05);
        cmd_bits("R3 one then cmd", 4'b1111);
        check("R3 sync_b kept", sync_b, 8'h2D);
    endtask

    task automatic t_data;
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; cd = 1'b0; bus_in = 8'hA5; #1;
        check("R7 load pulse", {7'd0, tx_load}, 8'h01);
        @(negedge clk);
        check("R7 pulse one", {7'd0, tx_load}, 8'h00);
        check("R7 data", tx_data, 8'hA5);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        cmd_bits("R7 no cmd", 4'b1111);
        // a control write still lands as a command
        bus_write(1'b1, 8'h21);
        cmd_bits("R7 state held", 4'b1001);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; cd = 1'b0; #1;
        check("R8 rx data", bus_out, 8'h3C);
        check("R8 take", {6'd0, rx_take, bus_oe}, 8'h03);
        @(negedge clk);
        check("R8 take once", {7'd0, rx_take}, 8'h00);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; cd = 1'b1; #1;
        check(req, bus_out, exp);
        check("R8 no take", {7'd0, rx_take}, 8'h00);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_status;
        rx_full = 1'b1; syn_det = 1'b1; dsr_n = 1'b0; tx_idle = 1'b0;
        read_status("R8 status", 8'hC3);
        rx_full = 1'b0; syn_det = 1'b0; dsr_n = 1'b1; tx_idle = 1'b1;
        @(negedge clk);
        ev_parity = 1'b1; ev_framing = 1'b1;
        @(negedge clk);
        ev_parity = 1'b0; ev_framing = 1'b0;
        repeat (3) @(negedge clk);
        read_status("R9 sticky", 8'h2D);
        // clear together with a new overrun event
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; cd = 1'b1; bus_in = 8'h11; ev_overrun = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; ev_overrun = 1'b0;
        @(negedge clk);
        read_status("R9 clear vs set", 8'h15);
        bus_write(1'b1, 8'h11);
        read_status("R9 cleared", 8'h05);
    endtask

    task automatic t_no_select;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; cd = 1'b1; bus_in = 8'h40;
        @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        cmd_bits("R10 wr ignored", 4'b1011);
        rd_n = 1'b0; #1;
        check("R10 oe off", {7'd0, bus_oe}, 8'h00);
        cs_n = 1'b0; #1;
        check("R10 oe on", {7'd0, bus_oe}, 8'h01);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_async_mode();
        t_break();
        t_internal_reset();
        t_two_sync();
        t_one_sync();
        t_data();
        t_status();
        t_no_select();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule